// File: doc/BRIEF.md
# Interrupt status and enable unit

This block gathers the event strobes of a USB peripheral controller into one interrupt request line. Seven single-cycle strobes (four endpoint-done events, DMA done, start-of-frame received and bus reset received) are each caught in a sticky status bit. A host register port reads and writes three byte-wide registers: an interrupt enable mask, a status register that is cleared by writing ones to it, and the device-address register. The interrupt line is a level. It stays high while any pending status bit is also enabled.

A status bit is caught whether or not its enable bit is set. The enable mask only decides which pending bits reach the interrupt line, so software can poll events that it has masked. Status bit 7 is not stored. It mirrors the live DMA-busy input and never takes part in the interrupt.

Top module: `usbdev_irq_regs`

## Requirements
- R1: After a synchronous reset the enable, status and device-address registers all read 00h, and irq is low.
- R2: A one-cycle strobe on an event input sets its status bit at the next clock edge, whatever the enable mask holds. The status bit positions are: bits 0..3 are endpoint 0..3 done, bit 4 is DMA done, bit 5 is start-of-frame, and bit 6 is bus reset.
- R3: A write to address 0Dh clears every status bit 0..6 whose write-data bit is 1. Status bits written as 0 keep their value, and a write to bit 7 has no effect.
- R4: When an event strobe and a write-one clear of the same status bit arrive in the same cycle, the bit ends up set.
- R5: irq is high exactly when some bit k in 0..6 has both status and enable set. It rises in the cycle after the edge that sets such a bit and falls after the edge that clears the last one.
- R6: A write to the enable register at address 06h leaves the status bits unchanged.
- R7: Status bit 7 reads the dma_busy input as sampled at the read edge, and it never drives irq.
- R8: The device-address register at address 07h stores and returns all 8 written bits.
- R9: Reads of addresses other than 06h, 07h and 0Dh return 00h. Bit 7 of the enable register always reads 0, and only enable bits 0..6 are stored.
- R10: host_rdata takes the selected register value one clock after a cycle with host_rd high, using the values held before that edge. It holds that value while host_rd stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ep_done | input | 4 | Endpoint 0..3 done strobes |
| ev_dma_done | input | 1 | DMA done strobe |
| ev_sof | input | 1 | Start-of-frame received strobe |
| ev_bus_reset | input | 1 | Bus reset received strobe |
| dma_busy | input | 1 | Live DMA-in-progress level |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
An event strobe or a register write takes effect at the clock edge that samples it. irq is combinational from the registers, so the bench reads it at the falling edge after that clock edge. A read returns its data on host_rdata one edge after host_rd is sampled. The driver queues each expected byte when it issues the read. The monitor pops that byte at the falling edge that follows the capturing rising edge, so every comparison lands in the cycle in which the result becomes valid.

// File: rtl/usbdev_irq_pkg.sv
package usbdev_irq_pkg;

    // Number of latched event sources (status bits 0..6)
    localparam int EVT_W  = 7;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 8'h06;
    localparam logic [ADDR_W-1:0] ADDR_DEVADDR = 8'h07;
    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 8'h0D;

    // Event bit positions
    typedef enum int {
        EVB_EP0   = 0,
        EVB_EP1   = 1,
        EVB_EP2   = 2,
        EVB_EP3   = 3,
        EVB_DMA   = 4,
        EVB_SOF   = 5,
        EVB_RESET = 6
    } evt_bit_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_DEVADDR,
        SEL_STATUS
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        reg_sel_e      sel;
    } host_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_ENABLE:  return SEL_ENABLE;
            ADDR_DEVADDR: return SEL_DEVADDR;
            ADDR_STATUS:  return SEL_STATUS;
            default:      return SEL_NONE;
        endcase
    endfunction

    // Status byte as seen by the host: live busy flag on top
    function automatic logic [DATA_W-1:0] status_view(
        input logic [EVT_W-1:0] st,
        input logic             busy
    );
        return {busy, st};
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
    import usbdev_irq_pkg::*;
#(
    parameter int N = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_i[i])
                    bit_q <= 1'b1;          // a new event beats a clear
                else if (clr_i[i])
                    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;
        end
    endgenerate
endmodule

// File: rtl/irq_host_reg.sv
module irq_host_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RST_VAL;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import usbdev_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req_i,
    input  logic [EVT_W-1:0]  status_i,
    input  logic              busy_i,
    input  logic [EVT_W-1:0]  enable_i,
    input  logic [DATA_W-1:0] devaddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        unique case (req_i.sel)
            SEL_ENABLE:  sel_data = {{(DATA_W-EVT_W){1'b0}}, enable_i};
            SEL_DEVADDR: sel_data = devaddr_i;
            SEL_STATUS:  sel_data = status_view(status_i, busy_i);
            default:     sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (req_i.rd)
            rdata_o <= sel_data;
    end
endmodule

// File: rtl/usbdev_irq_regs.sv
module usbdev_irq_regs
    import usbdev_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ev_ep_done,
    input  logic              ev_dma_done,
    input  logic              ev_sof,
    input  logic              ev_bus_reset,
    input  logic              dma_busy,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);
    host_req_t         req;
    logic [EVT_W-1:0]  ev_vec;
    logic [EVT_W-1:0]  clr_vec;
    logic [EVT_W-1:0]  status_q;
    logic [EVT_W-1:0]  enable_q;
    logic [DATA_W-1:0] devaddr_q;
    logic              en_we;
    logic              addr_we;

    assign req.wr  = host_wr;
    assign req.rd  = host_rd;
    assign req.sel = decode_addr(host_addr);

    assign ev_vec  = {ev_bus_reset, ev_sof, ev_dma_done, ev_ep_done};
    assign clr_vec = (req.wr && req.sel == SEL_STATUS) ? host_wdata[EVT_W-1:0] : '0;
    assign en_we   = req.wr && req.sel == SEL_ENABLE;
    assign addr_we = req.wr && req.sel == SEL_DEVADDR;

    irq_event_latch #(.N(EVT_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev_vec),
        .clr_i (clr_vec),
        .q_o   (status_q)
    );

    irq_host_reg #(.W(EVT_W)) u_enable (
        .clk  (clk),
        .rst  (rst),
        .we_i (en_we),
        .d_i  (host_wdata[EVT_W-1:0]),
        .q_o  (enable_q)
    );

    irq_host_reg #(.W(DATA_W)) u_devaddr (
        .clk  (clk),
        .rst  (rst),
        .we_i (addr_we),
        .d_i  (host_wdata),
        .q_o  (devaddr_q)
    );

    irq_read_mux u_rmux (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .status_i  (status_q),
        .busy_i    (dma_busy),
        .enable_i  (enable_q),
        .devaddr_i (devaddr_q),
        .rdata_o   (host_rdata)
    );

    assign irq = |(status_q & enable_q);
endmodule

// File: rtl/usbdev_irq_regs_chk.sv
module usbdev_irq_regs_chk
    import usbdev_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        ev_ep_done,
    input logic              ev_sof,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [EVT_W-1:0]  status_q,
    input logic [EVT_W-1:0]  enable_q,
    input logic [DATA_W-1:0] devaddr_q,
    input logic              irq
);
    logic wr_stat, wr_en, wr_addr;
    assign wr_stat = host_wr && host_addr == ADDR_STATUS;
    assign wr_en   = host_wr && host_addr == ADDR_ENABLE;
    assign wr_addr = host_wr && host_addr == ADDR_DEVADDR;

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == '0 && enable_q == '0 && devaddr_q == '0 && !irq));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        ev_ep_done[0] |=> status_q[0]);

    a_r3_one_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && host_wdata[0] && !ev_ep_done[0]) |=> !status_q[0]);

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !host_wdata[0] && status_q[0]) |=> status_q[0]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_sof && wr_stat && host_wdata[5]) |=> status_q[5]);

    a_r6_enable_write_keeps_status: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ev_ep_done == '0 && !ev_sof && status_q[6:5] == 2'b00) |=> status_q[3:0] == $past(status_q[3:0]));

    a_r7_no_pending_no_irq: assert property (@(posedge clk) disable iff (rst)
        ((status_q & enable_q) == '0) |-> !irq);

    a_r8_devaddr_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_addr |=> $stable(devaddr_q));
endmodule

bind usbdev_irq_regs usbdev_irq_regs_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ev_ep_done (ev_ep_done),
    .ev_sof     (ev_sof),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .devaddr_q  (devaddr_q),
    .irq        (irq)
);

// File: tb/usbdev_irq_regs_tb_top.sv
module usbdev_irq_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ev_ep_done = '0;
    logic       ev_dma_done = 1'b0, ev_sof = 1'b0, ev_bus_reset = 1'b0;
    logic       dma_busy = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbdev_irq_regs dut_i (
        .clk(clk), .rst(rst), .ev_ep_done(ev_ep_done), .ev_dma_done(ev_dma_done),
        .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset), .dma_busy(dma_busy),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    // Scoreboard of expected read bytes
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= host_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (host_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: read got %02h expected %02h", t, host_rdata, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string t);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        tick();
        host_rd = 1'b0;
        tick();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] m);
        {ev_bus_reset, ev_sof, ev_dma_done, ev_ep_done} = m;
        tick();
        {ev_bus_reset, ev_sof, ev_dma_done, ev_ep_done} = '0;
    endtask

    task automatic check_irq(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state, R9 unmapped read
        check_irq(1'b0, "R1 irq after reset");
        do_read(8'h06, 8'h00, "R1 enable reset");
        do_read(8'h07, 8'h00, "R1 devaddr reset");
        do_read(8'h0D, 8'h00, "R1 status reset");
        do_read(8'h55, 8'h00, "R9 unmapped read");

        // R2: every event sets its own bit with enable clear; R5 no irq while masked
        for (int i = 0; i < 7; i++) begin
            pulse(7'(1 << i));
            check_irq(1'b0, "R5 masked event no irq");
            do_read(8'h0D, 8'(1 << i), "R2 event bit position");
            do_write(8'h0D, 8'(1 << i));
            tick();
        end
        do_read(8'h0D, 8'h00, "R3 cleared after loop");

        // R6: enabling does not touch status; R5 irq rises
        pulse(7'h04);
        do_write(8'h06, 8'h04);
        check_irq(1'b1, "R5 enabled pending raises irq");
        do_read(8'h0D, 8'h04, "R6 status kept on enable write");
        do_read(8'h06, 8'h04, "R9 enable readback");

        // R3: zero writes and bit 7 write ignored
        do_write(8'h0D, 8'h00);
        do_write(8'h0D, 8'h80);
        tick();
        do_read(8'h0D, 8'h04, "R3 zeros keep status");

        // R9 enable bit 7 reads 0; R7 busy mirror no irq
        do_write(8'h06, 8'hFF);
        do_read(8'h06, 8'h7F, "R9 enable bit7 reads 0");
        dma_busy = 1'b1;
        do_write(8'h0D, 8'h04);
        tick();
        check_irq(1'b0, "R7 busy does not raise irq");
        do_read(8'h0D, 8'h80, "R7 busy mirrored in bit 7");
        dma_busy = 1'b0;
        do_read(8'h0D, 8'h00, "R7 busy cleared live");

        // R4 set wins over simultaneous clear
        ev_sof = 1'b1;
        do_write(8'h0D, 8'h20);
        ev_sof = 1'b0;
        check_irq(1'b1, "R4 set wins irq");
        do_read(8'h0D, 8'h20, "R4 set wins status");

        // R3/R5 multiple bits, partial clear
        pulse(7'h51);
        do_read(8'h0D, 8'h71, "R2 several events");
        do_write(8'h0D, 8'h20);
        tick();
        do_read(8'h0D, 8'h51, "R3 partial clear");
        check_irq(1'b1, "R5 irq held while pending");
        do_write(8'h0D, 8'h51);
        tick();
        check_irq(1'b0, "R5 irq falls after last clear");

        // R8 device address
        do_write(8'h07, 8'hA5);
        do_read(8'h07, 8'hA5, "R8 devaddr A5");
        do_write(8'h07, 8'h5A);
        do_read(8'h07, 8'h5A, "R8 devaddr 5A");

        // R10 rdata holds without host_rd
        pulse(7'h08);
        repeat (3) tick();
        n_checks++;
        if (host_rdata !== 8'h5A) begin
            n_fail++;
            $display("FAIL R10 rdata hold: got %02h expected 5a", host_rdata);
        end
        do_read(8'h0D, 8'h08, "R10 fresh read after hold");

        repeat (2) tick();
        finish_run();
    end
endmodule